// File: doc/BRIEF.md
# Complementary Drive Generator with Dead-Band Insertion

The block takes one of four input lines and produces two complementary drive outputs, A and B, for a pair of power switches. Each input edge turns the opposing drive off immediately. The drive that is about to turn on waits for a programmed number of clock periods first. A separate wait count applies to rising and to falling input edges. During that wait neither drive is on, so the two switches never conduct together.

Software programs three small registers through a write-only configuration port. The control register holds the module enable, an enable per output, a polarity per output and the source select. The other two registers hold the rising-edge wait count and the falling-edge wait count. The selected input is resynchronised to the block clock before edge detection. If a pulse ends before its wait count completes, the waiting drive never turns on. An edge that arrives while a count is still running cancels that count and starts timing for the new direction.

Top module: `comp_drive_gen`

## Requirements
- R1: After reset all configuration registers are zero, and drv_a, drv_b, drv_a_en and drv_b_en are all low.
- R2: Bits 6:5 of the control register (address 0) select which src_in line drives the block; changes on the other three lines have no effect on the outputs.
- R3: On a rising edge of the selected input, drive B turns inactive in the cycle the edge is processed, and drive A turns active exactly N clock periods later, where N is bits 5:0 of the rising count register (address 1).
- R4: On a falling edge of the selected input, drive A turns inactive in the cycle the edge is processed, and drive B turns active exactly M clock periods later, where M is bits 5:0 of the falling count register (address 2).
- R5: With a count of zero, the drive being turned on becomes active in the same cycle that the opposing drive turns inactive.
- R6: If the selected input returns to its previous level before the count for a drive completes, that drive stays inactive for the whole pulse.
- R7: An edge that arrives while a count is running cancels that count and starts timing from the new edge with the count for the new direction.
- R8: Control bit 3 (drive A) and bit 4 (drive B) select polarity: 1 drives logic 1 when active, 0 drives logic 0 when active and logic 1 when inactive.
- R9: drv_a_en equals module enable (control bit 0) AND control bit 1, and drv_b_en equals module enable AND control bit 2; when a qualifier is low its drive output is 0.
- R10: While the module enable is clear, both drives are held inactive; after enabling, both stay inactive until the first input edge seen while enabled.
- R11: Drives A and B are never active at the same time.
- R12: A level change on the selected input is acted on at the third rising clock edge after it appears at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; dead-band counts are in periods of this clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 4 | Candidate input source lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register address: 0 control, 1 rising count, 2 falling count |
| cfg_wdata | input | 8 | Write data |
| drv_a | output | 1 | Drive A output level |
| drv_b | output | 1 | Drive B output level |
| drv_a_en | output | 1 | Qualifier: block controls drive A |
| drv_b_en | output | 1 | Qualifier: block controls drive B |

## Verification
The hardest situation to reach is a reverse edge that lands inside a running count. That case covers both the cancelled pulse and the restart of timing for the opposite direction. The edge only has effect once it has passed through the synchroniser, so the bench drives inputs at the falling clock edge with the three-cycle latency known in advance. It then places the second edge a chosen number of cycles into the window. A queue-based reference model follows the selected line through the same latency and predicts both drives on every clock. Directed probes also measure the gap between one drive turning off and the other turning on, and check that gap against the programmed count.

// File: rtl/cdg_pkg.sv
// Package: shared widths, control-register bit positions and the
// configuration record used across the complementary drive generator.
// Assumes two outputs, indexed 0 for drive A and 1 for drive B.
package cdg_pkg;
    localparam int unsigned DB_W   = 6;
    localparam int unsigned SEL_W  = 2;
    localparam int unsigned ADDR_W = 2;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned NSRC   = 1 << SEL_W;

    // register addresses
    localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_RISE = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_FALL = 2'd2;

    // control register bit positions
    localparam int unsigned B_EN    = 0;
    localparam int unsigned B_OEA   = 1;
    localparam int unsigned B_OEB   = 2;
    localparam int unsigned B_POLA  = 3;
    localparam int unsigned B_POLB  = 4;
    localparam int unsigned B_SEL_L = 5;

    typedef struct packed {
        logic             mod_en;
        logic [1:0]       oe;
        logic [1:0]       pol;
        logic [SEL_W-1:0] sel;
        logic [DB_W-1:0]  db_rise;
        logic [DB_W-1:0]  db_fall;
    } cfg_t;
endpackage

// File: rtl/cdg_cfg_regs.sv
// Configuration registers: control, rising count and falling count.
// Writes take effect at the clock edge where cfg_we is sampled high.
// Assumes write-only access; unused data bits are ignored.
module cdg_cfg_regs
    import cdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg
);
    logic unused_wbits;
    assign unused_wbits = &{1'b0, wdata[DATA_W-1:B_SEL_L+SEL_W]};

    // Register update on write strobe, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            case (addr)
                ADR_CTRL: begin
                    cfg.mod_en <= wdata[B_EN];
                    cfg.oe     <= {wdata[B_OEB], wdata[B_OEA]};
                    cfg.pol    <= {wdata[B_POLB], wdata[B_POLA]};
                    cfg.sel    <= wdata[B_SEL_L +: SEL_W];
                end
                ADR_RISE: cfg.db_rise <= wdata[DB_W-1:0];
                ADR_FALL: cfg.db_fall <= wdata[DB_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cdg_sync_edge.sv
// Source selection, synchroniser and edge detector.
// Assumes src lines are asynchronous to clk; STAGES must be at least 2.
// rise/fall are one-cycle pulses; level is the last processed input level.
module cdg_sync_edge #(
    parameter int unsigned NSRC   = 4,
    parameter int unsigned SEL_W  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src,
    input  logic [SEL_W-1:0] sel,
    output logic             rise,
    output logic             fall,
    output logic             level
);
    logic              sel_in;
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              now_lvl;

    // Pick the configured source line.
    always_comb sel_in = src[sel];

    // Shift the selected line through the synchroniser and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], sel_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Compare newest synchronised sample against the previous one.
    always_comb begin
        now_lvl = sync_q[STAGES-1];
        rise    = now_lvl & ~prev_q;
        fall    = ~now_lvl & prev_q;
        level   = prev_q;
    end
endmodule

// File: rtl/cdg_dly_timer.sv
// Delayed turn-on for one drive. 'kill' turns the drive off at once and
// cancels timing; 'start' begins counting clock periods up to 'limit',
// after which the drive turns on. A zero limit turns it on at the start edge.
// Assumes kill and start are never high together.
module cdg_dly_timer #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start,
    input  logic             kill,
    input  logic [CNT_W-1:0] limit,
    output logic             act
);
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic [CNT_W:0]   cnt_nxt;

    // Next elapsed-period value, one bit wider to avoid wrap.
    always_comb cnt_nxt = {1'b0, cnt_q} + 1'b1;

    // Drive state and dead-band counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            act    <= 1'b0;
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (kill) begin
            act    <= 1'b0;
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            act    <= (limit == '0);
            busy_q <= (limit != '0);
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_nxt >= {1'b0, limit}) begin
                act    <= 1'b1;
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_nxt[CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/cdg_out_stage.sv
// Output qualification and polarity for both drives.
// Assumes index 0 is drive A and index 1 is drive B.
module cdg_out_stage #(
    parameter int unsigned NOUT = 2
) (
    input  logic            mod_en,
    input  logic [NOUT-1:0] oe,
    input  logic [NOUT-1:0] pol,
    input  logic [NOUT-1:0] act,
    output logic [NOUT-1:0] drv,
    output logic [NOUT-1:0] drv_en
);
    for (genvar i = 0; i < NOUT; i++) begin : g_out
        // Qualify with enables and map active state to the selected level.
        always_comb begin
            drv_en[i] = mod_en & oe[i];
            drv[i]    = drv_en[i] ? (pol[i] ? act[i] : ~act[i]) : 1'b0;
        end
    end
endmodule

// File: rtl/comp_drive_gen.sv
// Complementary drive generator with separate rising and falling dead bands.
// Assumes a single block clock, synchronous active-low reset and
// asynchronous source lines. Output drives are combinational from state.
module comp_drive_gen
    import cdg_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_in,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              drv_a,
    output logic              drv_b,
    output logic              drv_a_en,
    output logic              drv_b_en
);
    localparam int unsigned NOUT = 2;

    cfg_t            cfg_q;
    logic            mod_en;
    logic            rise_p, fall_p, lvl;
    logic [DB_W-1:0] rise_lim, fall_lim;
    logic [NOUT-1:0] act;
    logic [NOUT-1:0] start_v, kill_v;
    logic [DB_W-1:0] lim_v [NOUT];
    logic [NOUT-1:0] drv_v, drv_en_v;

    cdg_cfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    cdg_sync_edge #(.NSRC(NSRC), .SEL_W(SEL_W), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src_in),
        .sel   (cfg_q.sel),
        .rise  (rise_p),
        .fall  (fall_p),
        .level (lvl)
    );

    // Route edge pulses and counts: A turns on after a rise, B after a fall.
    always_comb begin
        mod_en     = cfg_q.mod_en;
        rise_lim   = cfg_q.db_rise;
        fall_lim   = cfg_q.db_fall;
        start_v    = {fall_p, rise_p};
        kill_v     = {rise_p, fall_p};
        lim_v[0]   = rise_lim;
        lim_v[1]   = fall_lim;
    end

    for (genvar i = 0; i < NOUT; i++) begin : g_tmr
        cdg_dly_timer #(.CNT_W(DB_W)) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (mod_en),
            .start (start_v[i]),
            .kill  (kill_v[i]),
            .limit (lim_v[i]),
            .act   (act[i])
        );
    end

    cdg_out_stage #(.NOUT(NOUT)) u_out (
        .mod_en (mod_en),
        .oe     (cfg_q.oe),
        .pol    (cfg_q.pol),
        .act    (act),
        .drv    (drv_v),
        .drv_en (drv_en_v)
    );

    // Map vector outputs onto named ports.
    always_comb begin
        drv_a    = drv_v[0];
        drv_b    = drv_v[1];
        drv_a_en = drv_en_v[0];
        drv_b_en = drv_en_v[1];
    end
endmodule

// File: rtl/cdg_checker.sv
// Property checker for comp_drive_gen, attached by bind below.
// Observes edge pulses, timer states, enables and qualifiers.
module cdg_checker
    import cdg_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            mod_en,
    input logic            rise_p,
    input logic            fall_p,
    input logic            lvl,
    input logic [DB_W-1:0] rise_lim,
    input logic [DB_W-1:0] fall_lim,
    input logic            act_a,
    input logic            act_b,
    input logic            drv_a_en,
    input logic            drv_b_en
);
    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_a && act_b));

    assert_rise_kills_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_p && mod_en) |=> !act_b);

    assert_fall_kills_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_p && mod_en) |=> !act_a);

    assert_zero_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_p && mod_en && rise_lim == '0) |=> act_a);

    assert_zero_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_p && mod_en && fall_lim == '0) |=> act_b);

    assert_a_on_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_a) |-> lvl);

    assert_b_on_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_b) |-> !lvl);

    assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> (!act_a && !act_b));

    assert_qual_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |-> (!drv_a_en && !drv_b_en));
endmodule

bind comp_drive_gen cdg_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mod_en   (mod_en),
    .rise_p   (rise_p),
    .fall_p   (fall_p),
    .lvl      (lvl),
    .rise_lim (rise_lim),
    .fall_lim (fall_lim),
    .act_a    (act[0]),
    .act_b    (act[1]),
    .drv_a_en (drv_a_en),
    .drv_b_en (drv_b_en)
);

// File: tb/comp_drive_gen_bench.sv
// Bench: behavioural reference model compared on every clock plus directed probes.
module comp_drive_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_in = '0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       drv_a, drv_b, drv_a_en, drv_b_en;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    comp_drive_gen u_comp_drive_gen (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .drv_a(drv_a), .drv_b(drv_b), .drv_a_en(drv_a_en), .drv_b_en(drv_b_en)
    );

    task automatic chk(string req, string what, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic chk_int(string req, string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int   hq[$];
    int   mdir, el;
    logic m_en, m_oea, m_oeb, m_pola, m_polb;
    int   m_sel, m_dbr, m_dbf;

    always @(posedge clk) begin
        if (!rst_n) begin
            hq = '{0, 0, 0};
            mdir = -1; el = 0;
            m_en = 0; m_oea = 0; m_oeb = 0; m_pola = 0; m_polb = 0;
            m_sel = 0; m_dbr = 0; m_dbf = 0;
        end else begin
            // hq holds pin samples from three, two and one clocks back
            if (!m_en) begin mdir = -1; el = 0; end
            else if (hq[1] != hq[0]) begin mdir = hq[1]; el = 0; end
            else if (el < 1000) el++;
            hq.push_back(int'(src_in[m_sel]));
            void'(hq.pop_front());
            if (cfg_we) begin
                case (cfg_addr)
                    2'd0: begin
                        m_en = cfg_wdata[0]; m_oea = cfg_wdata[1]; m_oeb = cfg_wdata[2];
                        m_pola = cfg_wdata[3]; m_polb = cfg_wdata[4];
                        m_sel = int'(cfg_wdata[6:5]);
                    end
                    2'd1: m_dbr = int'(cfg_wdata[5:0]);
                    2'd2: m_dbf = int'(cfg_wdata[5:0]);
                    default: ;
                endcase
            end
        end
    end

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            logic ea, eb, qa, qb;
            ea = (mdir == 1) && (el >= m_dbr);
            eb = (mdir == 0) && (el >= m_dbf);
            qa = m_en && m_oea;
            qb = m_en && m_oeb;
            chk(cur_req, "drv_a_en", drv_a_en, qa);
            chk(cur_req, "drv_b_en", drv_b_en, qb);
            chk(cur_req, "drv_a", drv_a, qa ? (m_pola ? ea : !ea) : 1'b0);
            chk(cur_req, "drv_b", drv_b, qb ? (m_polb ? eb : !eb) : 1'b0);
        end
    end

    // ---------------- helpers ----------------
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic ctrl(bit en, bit oea, bit oeb, bit pola, bit polb, logic [1:0] sel);
        wr(2'd0, {1'b0, sel, polb, pola, oeb, oea, en});
    endtask

    task automatic setsrc(int idx, logic v);
        @(negedge clk);
        src_in[idx] = v;
    endtask

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive a rising edge on line idx and measure both latency and gap (pol high).
    task automatic probe_rise(int idx, int d, string req);
        int t_off = -1, t_on = -1;
        @(negedge clk);
        src_in[idx] = 1'b1;
        for (int k = 1; k <= 100; k++) begin
            @(negedge clk);
            if (t_off < 0 && drv_b == 1'b0) t_off = k;
            if (t_on < 0 && drv_a == 1'b1) t_on = k;
        end
        chk_int("R12", "cycles pin-to-B-off", t_off, 3);
        chk_int(req, "B-off to A-on gap", t_on - t_off, d);
    endtask

    task automatic probe_fall(int idx, int d, string req);
        int t_off = -1, t_on = -1;
        @(negedge clk);
        src_in[idx] = 1'b0;
        for (int k = 1; k <= 100; k++) begin
            @(negedge clk);
            if (t_off < 0 && drv_a == 1'b0) t_off = k;
            if (t_on < 0 && drv_b == 1'b1) t_on = k;
        end
        chk_int("R12", "cycles pin-to-A-off", t_off, 3);
        chk_int(req, "A-off to B-on gap", t_on - t_off, d);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        waitn(4);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", "reset drv_a", drv_a, 1'b0);
        chk("R1", "reset drv_b", drv_b, 1'b0);
        chk("R1", "reset drv_a_en", drv_a_en, 1'b0);
        chk("R1", "reset drv_b_en", drv_b_en, 1'b0);
        cmp_on = 1'b1;

        // R2: select line 2, wiggle the others
        cur_req = "R2";
        wr(2'd1, 8'd3);
        wr(2'd2, 8'd5);
        ctrl(1, 1, 1, 1, 1, 2'd2);
        setsrc(2, 1'b1); waitn(12);
        for (int j = 0; j < 6; j++) begin
            setsrc(0, j[0]); setsrc(1, ~j[0]); setsrc(3, j[1]);
        end
        waitn(4);
        chk("R2", "A held by selected line", drv_a, 1'b1);
        setsrc(2, 1'b0); waitn(12);
        src_in = '0; waitn(4);

        // R3 / R4 / R12: measured gaps on line 2
        cur_req = "R3";
        probe_rise(2, 3, "R3");
        cur_req = "R4";
        probe_fall(2, 5, "R4");
        wr(2'd1, 8'd63); wr(2'd2, 8'd1);
        cur_req = "R3";
        probe_rise(2, 63, "R3");
        cur_req = "R4";
        probe_fall(2, 1, "R4");

        // R5: zero counts
        cur_req = "R5";
        wr(2'd1, 8'd0); wr(2'd2, 8'd0);
        probe_rise(2, 0, "R5");
        probe_fall(2, 0, "R5");
        for (int j = 0; j < 6; j++) begin setsrc(2, ~src_in[2]); waitn(j + 1); end
        setsrc(2, 1'b0); waitn(6);

        // R6: pulse shorter than rising count
        cur_req = "R6";
        wr(2'd1, 8'd10); wr(2'd2, 8'd2);
        waitn(4);
        begin
            bit a_seen = 1'b0;
            setsrc(2, 1'b1);
            for (int k = 0; k < 4; k++) begin @(negedge clk); if (drv_a) a_seen = 1'b1; end
            src_in[2] = 1'b0;
            for (int k = 0; k < 30; k++) begin @(negedge clk); if (drv_a) a_seen = 1'b1; end
            chk("R6", "A never on for short pulse", a_seen, 1'b0);
        end

        // R7: reverse edges inside running counts restart timing
        cur_req = "R7";
        wr(2'd1, 8'd8); wr(2'd2, 8'd8);
        waitn(4);
        setsrc(2, 1'b1); waitn(3);
        setsrc(2, 1'b0); waitn(5);
        chk("R7", "B still waiting after restart", drv_b, 1'b0);
        setsrc(2, 1'b1); waitn(6);
        chk("R7", "A still waiting after second restart", drv_a, 1'b0);
        waitn(6);
        chk("R7", "A on after full count", drv_a, 1'b1);
        setsrc(2, 1'b0); waitn(14);

        // R8: active-low polarity, source 1
        cur_req = "R8";
        wr(2'd1, 8'd2); wr(2'd2, 8'd2);
        ctrl(1, 1, 1, 0, 0, 2'd1);
        setsrc(1, 1'b1); waitn(8);
        chk("R8", "active-low A active", drv_a, 1'b0);
        chk("R8", "active-low B inactive", drv_b, 1'b1);
        setsrc(1, 1'b0); waitn(8);
        ctrl(1, 1, 1, 1, 0, 2'd1);
        setsrc(1, 1'b1); waitn(8);
        chk("R8", "mixed polarity B inactive", drv_b, 1'b1);

        // R9: per-output enables
        cur_req = "R9";
        ctrl(1, 0, 1, 1, 1, 2'd1);
        waitn(2);
        chk("R9", "A qualifier off", drv_a_en, 1'b0);
        chk("R9", "A drive zero when unqualified", drv_a, 1'b0);
        setsrc(1, 1'b0); waitn(8);
        ctrl(1, 1, 0, 1, 1, 2'd1);
        waitn(2);
        chk("R9", "B qualifier off", drv_b_en, 1'b0);
        setsrc(1, 1'b1); waitn(8);

        // R10: disable and re-enable
        cur_req = "R10";
        ctrl(0, 1, 1, 1, 1, 2'd1);
        waitn(4);
        chk("R10", "disabled A drive", drv_a, 1'b0);
        ctrl(1, 1, 1, 1, 1, 2'd1);
        waitn(6);
        chk("R10", "A inactive after enable until edge", drv_a, 1'b0);
        chk("R10", "B inactive after enable until edge", drv_b, 1'b0);
        setsrc(1, 1'b0); waitn(8);
        chk("R10", "B on after first edge", drv_b, 1'b1);

        // R11: rapid toggling with mixed counts, model compare guards overlap
        cur_req = "R11";
        ctrl(1, 1, 1, 1, 1, 2'd3);
        wr(2'd1, 8'd1); wr(2'd2, 8'd4);
        for (int j = 0; j < 40; j++) begin
            setsrc(3, ~src_in[3]);
            waitn((j * 7) % 9);
            n_chk++;
            if (drv_a && drv_b) begin
                n_fail++;
                $display("FAIL R11 overlap: actual 1 expected 0");
            end
        end
        waitn(10);

        cmp_on = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule